// File: doc/BRIEF.md
# CORDIC NCO Real-to-Complex Mixer

This block moves a real intermediate-frequency sample stream down to complex baseband. A 28-bit phase accumulator advances by a programmable tuning word on every accepted sample. The accumulated phase drives a pipelined CORDIC rotator. The rotator returns the cosine and sine of that phase without any stored waveform. Each real input sample is then multiplied by both to give an in-phase and a quadrature result.

The input is a signed 14-bit converter sample qualified by a valid strobe. The tuning word is written through a load strobe. The two 16-bit results leave together under one output valid, a fixed number of cycles after the sample that produced them. With a 61.44 MSPS input, one tuning step is about 0.23 Hz. The input sample is carried through the rotator pipeline next to its own phase, so every sample meets the sinusoid values of its own phase. Amplitude is scaled so that a full-scale input at zero phase uses the full 16-bit output range.

Top module: `cordic_nco_mixer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `out_i` and `out_q` are 0. The accumulator phase and the active tuning word both restart from 0.
- R2: The phase of the first valid sample after reset is 0. Sample n+1 uses the phase of sample n plus the active tuning word, modulo 2^28. Cycles with `in_valid` low leave the phase unchanged.
- R3: A word presented with `tune_load` high becomes the active tuning word at that clock edge. An accumulator update on that same edge still adds the previous word. The phase is never reset by a load.
- R4: With phase P, θ = 2π·P/2^28. `out_i` equals round(x·cos θ·4) within ±3 LSB, where x is the signed input sample. A zero sample gives exactly zero on both outputs.
- R5: `out_q` equals round(x·sin θ·4) within ±3 LSB, using the same θ as R4.
- R6: Results beyond the 16-bit signed range saturate to 32767 or -32768 and do not wrap.
- R7: Each valid input produces exactly one valid output, in input order. It appears 18 clock edges after the edge that samples the input.
- R8: The full 0 to 2π phase circle is covered. All four quadrants give the correct signs, including when the accumulator wraps.
- R9: While `out_valid` is low, `out_i` and `out_q` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_sample | input | 14 | Signed real IF sample |
| tune_load | input | 1 | Load strobe for the tuning word |
| tune_word | input | 28 | Phase increment per valid sample |
| out_valid | output | 1 | Output pair qualifier |
| out_i | output | 16 | Signed in-phase result |
| out_q | output | 16 | Signed quadrature result |

## Verification
Several properties are checked on every cycle: the output valid matches a delayed copy of the input valid, the outputs hold while not valid, the phase stays frozen on idle cycles, a zero sample yields zero outputs, and the reset values appear. The numerical content can only be shown by the bench scenarios, which compare against a real-valued trigonometric model. That content covers cosine and sine accuracy, quadrant signs, saturation at the corners, tuning loads on busy and idle cycles, and accumulator wrap.

// File: rtl/cnm_pkg.sv
package cnm_pkg;

  typedef enum logic [1:0] {QUAD_0, QUAD_90, QUAD_180, QUAD_270} quad_t;

  // Arctangent of 2^-i, in units where a full turn equals 2^ang_w.
  function automatic int atan_step(input int i, input int ang_w);
    real a;
    a = $atan(1.0 / (2.0 ** i));
    return int'(a * (2.0 ** ang_w) / (2.0 * 3.141592653589793));
  endfunction

  // Reciprocal of the CORDIC growth after iters steps, scaled by 2^frac.
  function automatic int gain_seed(input int iters, input int frac);
    real k;
    k = 1.0;
    for (int i = 0; i < iters; i++) k = k / $sqrt(1.0 + 1.0 / (2.0 ** (2 * i)));
    return int'(k * (2.0 ** frac));
  endfunction

endpackage

// File: rtl/cnm_phase_acc.sv
module cnm_phase_acc #(
  parameter int PACC_W = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              tune_load,
  input  logic [PACC_W-1:0] tune_word,
  output logic [PACC_W-1:0] phase_o
);

  logic [PACC_W-1:0] step_q;
  logic [PACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      acc_q  <= '0;
    end else begin
      if (in_valid)  acc_q  <= acc_q + step_q;
      if (tune_load) step_q <= tune_word;
    end
  end

  assign phase_o = acc_q;

endmodule

// File: rtl/cnm_cordic.sv
module cnm_cordic import cnm_pkg::*; #(
  parameter int ANG_W  = 20,
  parameter int CW     = 22,
  parameter int CFRAC  = 19,
  parameter int ITER   = 16,
  parameter int SAMP_W = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [ANG_W-1:0]         angle,
  input  logic signed [SAMP_W-1:0] in_sample,
  output logic                     out_valid,
  output logic signed [CW-1:0]     cos_o,
  output logic signed [CW-1:0]     sin_o,
  output logic signed [SAMP_W-1:0] sample_o
);

  localparam int RES_W = ANG_W - 2;
  localparam logic signed [CW-1:0] KSEED = CW'(gain_seed(ITER, CFRAC));

  logic signed [CW-1:0]     xs [0:ITER];
  logic signed [CW-1:0]     ys [0:ITER];
  logic signed [ANG_W-1:0]  zs [0:ITER];
  logic signed [SAMP_W-1:0] ss [0:ITER];
  logic                     vs [0:ITER];

  // Quadrant pre-rotation: the seed vector already points at the quadrant.
  quad_t quad;
  logic signed [CW-1:0] seed_x, seed_y;
  assign quad = quad_t'(angle[ANG_W-1 -: 2]);

  always_comb begin
    case (quad)
      QUAD_0:   begin seed_x = KSEED; seed_y = '0;     end
      QUAD_90:  begin seed_x = '0;    seed_y = KSEED;  end
      QUAD_180: begin seed_x = -KSEED; seed_y = '0;    end
      default:  begin seed_x = '0;    seed_y = -KSEED; end
    endcase
  end

  logic signed [CW-1:0]     x0_q, y0_q;
  logic signed [ANG_W-1:0]  z0_q;
  logic signed [SAMP_W-1:0] s0_q;
  logic                     v0_q;

  always_ff @(posedge clk) begin
    if (rst) v0_q <= 1'b0;
    else     v0_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    x0_q <= seed_x;
    y0_q <= seed_y;
    z0_q <= {2'b00, angle[RES_W-1:0]};
    s0_q <= in_sample;
  end

  assign xs[0] = x0_q;
  assign ys[0] = y0_q;
  assign zs[0] = z0_q;
  assign ss[0] = s0_q;
  assign vs[0] = v0_q;

  for (genvar g = 0; g < ITER; g++) begin : g_rot
    localparam logic signed [ANG_W-1:0] ASTEP = ANG_W'(atan_step(g, ANG_W));
    logic signed [CW-1:0]     xq, yq;
    logic signed [ANG_W-1:0]  zq;
    logic signed [SAMP_W-1:0] sq;
    logic                     vq;

    always_ff @(posedge clk) begin
      if (rst) vq <= 1'b0;
      else     vq <= vs[g];
    end

    always_ff @(posedge clk) begin
      if (zs[g][ANG_W-1] == 1'b0) begin
        xq <= xs[g] - (ys[g] >>> g);
        yq <= ys[g] + (xs[g] >>> g);
        zq <= zs[g] - ASTEP;
      end else begin
        xq <= xs[g] + (ys[g] >>> g);
        yq <= ys[g] - (xs[g] >>> g);
        zq <= zs[g] + ASTEP;
      end
      sq <= ss[g];
    end

    assign xs[g+1] = xq;
    assign ys[g+1] = yq;
    assign zs[g+1] = zq;
    assign ss[g+1] = sq;
    assign vs[g+1] = vq;
  end

  logic unused_z;
  assign unused_z = ^zs[ITER];

  assign cos_o     = xs[ITER];
  assign sin_o     = ys[ITER];
  assign sample_o  = ss[ITER];
  assign out_valid = vs[ITER];

endmodule

// File: rtl/cnm_mix_rs.sv
module cnm_mix_rs #(
  parameter int SAMP_W = 14,
  parameter int CW     = 22,
  parameter int OUT_W  = 16,
  parameter int SHIFT  = 17,
  parameter int LANES  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [SAMP_W-1:0] sample,
  input  logic signed [CW-1:0]     coef [LANES],
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  result [LANES]
);

  localparam int PW = SAMP_W + CW;
  localparam logic signed [PW:0] MAXV = (PW+1)'((2 ** (OUT_W-1)) - 1);
  localparam logic signed [PW:0] MINV = -MAXV - 1;
  localparam logic signed [PW:0] HALF = (PW+1)'(2 ** (SHIFT-1));

  logic mid_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      mid_v     <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      mid_v     <= in_valid;
      out_valid <= mid_v;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PW-1:0]    prod_q;
    logic signed [PW:0]      rnd, shf;
    logic signed [OUT_W-1:0] sat;

    always_ff @(posedge clk) begin
      prod_q <= PW'(sample) * PW'(coef[l]);
    end

    always_comb begin
      rnd = {prod_q[PW-1], prod_q} + HALF;
      shf = rnd >>> SHIFT;
      if (shf > MAXV)      sat = MAXV[OUT_W-1:0];
      else if (shf < MINV) sat = MINV[OUT_W-1:0];
      else                 sat = shf[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
      if (rst)        result[l] <= '0;
      else if (mid_v) result[l] <= sat;
    end
  end

endmodule

// File: rtl/cordic_nco_mixer.sv
module cordic_nco_mixer #(
  parameter int SAMP_W = 14,
  parameter int OUT_W  = 16,
  parameter int PACC_W = 28,
  parameter int ANG_W  = 20,
  parameter int CW     = 22,
  parameter int CFRAC  = 19,
  parameter int ITER   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [SAMP_W-1:0] in_sample,
  input  logic                     tune_load,
  input  logic [PACC_W-1:0]        tune_word,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_i,
  output logic signed [OUT_W-1:0]  out_q
);

  localparam int SHIFT   = CFRAC - (OUT_W - SAMP_W);
  localparam int LATENCY = ITER + 2;

  logic [PACC_W-1:0]        phase;
  logic                     rot_v;
  logic signed [CW-1:0]     rot_cos, rot_sin;
  logic signed [SAMP_W-1:0] rot_samp;
  logic signed [CW-1:0]     coefs [2];
  logic signed [OUT_W-1:0]  res [2];

  cnm_phase_acc #(.PACC_W(PACC_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .tune_load (tune_load),
    .tune_word (tune_word),
    .phase_o   (phase)
  );

  cnm_cordic #(
    .ANG_W(ANG_W), .CW(CW), .CFRAC(CFRAC), .ITER(ITER), .SAMP_W(SAMP_W)
  ) u_rot (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .angle     (phase[PACC_W-1 -: ANG_W]),
    .in_sample (in_sample),
    .out_valid (rot_v),
    .cos_o     (rot_cos),
    .sin_o     (rot_sin),
    .sample_o  (rot_samp)
  );

  assign coefs[0] = rot_cos;
  assign coefs[1] = rot_sin;

  cnm_mix_rs #(
    .SAMP_W(SAMP_W), .CW(CW), .OUT_W(OUT_W), .SHIFT(SHIFT), .LANES(2)
  ) u_mix (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (rot_v),
    .sample    (rot_samp),
    .coef      (coefs),
    .out_valid (out_valid),
    .result    (res)
  );

  assign out_i = res[0];
  assign out_q = res[1];

endmodule

// File: rtl/cnm_chk.sv
module cnm_chk #(
  parameter int DLY    = 18,
  parameter int SAMP_W = 14,
  parameter int OUT_W  = 16,
  parameter int PACC_W = 28
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic signed [SAMP_W-1:0] in_sample,
  input logic                     out_valid,
  input logic signed [OUT_W-1:0]  out_i,
  input logic signed [OUT_W-1:0]  out_q,
  input logic [PACC_W-1:0]        phase
);

  logic [DLY:0] vline, zline;

  always_ff @(posedge clk) begin
    if (rst) begin
      vline <= '0;
      zline <= '0;
    end else begin
      vline <= {vline[DLY-1:0], in_valid};
      zline <= {zline[DLY-1:0], in_valid && (in_sample == '0)};
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_i == '0 && out_q == '0));

  a_r2_phase_frozen: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase));

  a_r4_zero_sample: assert property (@(posedge clk) disable iff (rst)
    (out_valid && zline[DLY]) |-> (out_i == '0 && out_q == '0));

  a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == vline[DLY]);

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

endmodule

bind cordic_nco_mixer cnm_chk #(
  .DLY(LATENCY), .SAMP_W(SAMP_W), .OUT_W(OUT_W), .PACC_W(PACC_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_sample (in_sample),
  .out_valid (out_valid),
  .out_i     (out_i),
  .out_q     (out_q),
  .phase     (phase)
);

// File: tb/cordic_nco_mixer_tb_top.sv
`timescale 1ns/1ps
module cordic_nco_mixer_tb_top;

  localparam int LAT = 18;
  localparam int TOL = 3;
  localparam real PI = 3.141592653589793;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [13:0] in_sample = '0;
  logic tune_load = 1'b0;
  logic [27:0] tune_word = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #2 clk = ~clk;

  cordic_nco_mixer dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .tune_load(tune_load), .tune_word(tune_word),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [27:0] m_phase = '0;
  logic [27:0] m_step = '0;
  bit vline [0:LAT];
  int exp_i [$];
  int exp_q [$];
  string exp_tag [$];
  int last_i = 0;
  int last_q = 0;

  function automatic int clamp16(input real r);
    int v;
    v = $rtoi($floor(r + 0.5));
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  task automatic chk(input string tag, input int act, input int expv, input int tol);
    n_chk++;
    if (act - expv > tol || expv - act > tol) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic tick(input bit v, input int x, input bit ld, input logic [27:0] w, input string tag);
    real th;
    in_valid = v;
    in_sample = 14'(x);
    tune_load = ld;
    tune_word = w;
    if (v) begin
      th = 2.0 * PI * real'(m_phase) / (2.0 ** 28);
      exp_i.push_back(clamp16(real'(x) * $cos(th) * 4.0));
      exp_q.push_back(clamp16(real'(x) * $sin(th) * 4.0));
      exp_tag.push_back(tag);
      m_phase = m_phase + m_step;
    end
    if (ld) m_step = w;
    for (int j = LAT; j > 0; j--) vline[j] = vline[j-1];
    vline[0] = v;
    @(negedge clk);
    chk("R7 valid timing", int'(out_valid), int'(vline[LAT]), 0);
    if (out_valid) begin
      if (exp_i.size() == 0) begin
        chk("R7 unexpected output", 1, 0, 0);
      end else begin
        string t;
        t = exp_tag.pop_front();
        chk({t, " in-phase"}, int'(out_i), exp_i.pop_front(), TOL);
        chk({t, " quadrature"}, int'(out_q), exp_q.pop_front(), TOL);
      end
      last_i = int'(out_i);
      last_q = int'(out_q);
    end else begin
      chk("R9 hold I", int'(out_i), last_i, 0);
      chk("R9 hold Q", int'(out_q), last_q, 0);
    end
  endtask

  initial begin
    for (int j = 0; j <= LAT; j++) vline[j] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset valid", int'(out_valid), 0, 0);
    chk("R1 reset I", int'(out_i), 0, 0);
    chk("R1 reset Q", int'(out_q), 0, 0);

    // Zero phase, zero step: I = 4x, Q = 0
    tick(1, 1000, 0, 0, "R4/R5 phase zero");
    tick(1, -8192, 0, 0, "R4/R5 phase zero");
    tick(1, 8191, 0, 0, "R2 first phase zero");
    tick(1, 0, 0, 0, "R4 zero sample");
    tick(0, 0, 0, 0, "idle");

    // Quarter-turn step walks all quadrants
    tick(0, 0, 1, 28'h400_0000, "R3 idle load");
    for (int k = 0; k < 8; k++) tick(1, 5000, 0, 0, "R8 quadrant");
    // Negative full scale hits saturation at 180 and 270 degrees
    for (int k = 0; k < 4; k++) tick(1, -8192, 0, 0, "R6 saturation");

    // Odd step with bubbles: phase holds on idle cycles
    tick(0, 0, 1, 28'h123_4567, "R3 idle load");
    for (int k = 0; k < 40; k++) begin
      tick(1, int'($urandom_range(16383)) - 8192, 0, 0, "R2 bubbles");
      if (k % 3 == 0) tick(0, 7, 0, 0, "idle");
    end

    // Load in the same cycle as a sample: new step from the next update
    tick(1, 6000, 1, 28'h0AB_CDEF, "R3 busy load");
    for (int k = 0; k < 10; k++) tick(1, 6000 - 700 * k, 0, 0, "R3 after load");

    // Large step: accumulator wraps modulo 2^28 every few samples
    tick(1, 3000, 1, 28'hF9A_5C31, "R8 wrap");
    for (int k = 0; k < 60; k++)
      tick(1, int'($urandom_range(16383)) - 8192, 0, 0, "R8 wrap");

    for (int k = 0; k < LAT + 3; k++) tick(0, 0, 0, 0, "drain");
    chk("R7 all outputs seen", exp_i.size(), 0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule